// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit core that runs in seven operating modes. Software sees sixteen register numbers, but behind them sit thirty general-purpose storage words, a current status word and five saved status words. The mode field of the current status word decides which physical word a register number reaches. The fast-interrupt mode owns private copies of registers 8 to 14. The other exception modes own private copies of registers 13 and 14 only. Everything else is shared with user mode. Register 15 is never stored here. Reads of it return the fetch stage's program counter, and writes to it leave on a branch output.

The block has two combinational read ports and one write port for general registers. It has one read port and one byte-masked write port for status words, and it applies the privilege rules to every status write. An exception sequencer gets a dedicated entry port. In a single cycle that port saves the current status word into the target mode's saved status word, loads that mode's link register, and switches the mode.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every general register reads 0, and the status word reads 0x000000D3: supervisor mode 10011, with bit 7 (IRQ mask) and bit 6 (fast-interrupt mask) set.
- R2: Registers 0 to 7 are one set shared by every mode. A value written in any mode reads back unchanged in every other mode.
- R3: In fast-interrupt mode (10001), registers 8 to 14 reach a private set. Values written there do not appear in any other mode, and values from other modes do not appear there.
- R4: In IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) modes, registers 13 and 14 are private to each mode. Registers 8 to 12 are shared with user mode.
- R5: System mode (11111) and every mode encoding not listed in R3, R4 or R8 use the user (10000) register set.
- R6: A read of register 15 on either port returns `pc_in`. A write to register 15 drives `br_valid` high with `br_target` equal to the written data in the same cycle, and it changes no stored register.
- R7: In a privileged mode, a status write changes only the bytes whose mask bit is set. Mask bit 3 selects bits 31..24, bit 2 selects bits 23..16, bit 1 selects bits 15..8, and bit 0 selects bits 7..0.
- R8: In user mode (10000) or an unlisted mode encoding, a status write changes only bits 31..24. The other bytes of the status word are left unchanged.
- R9: Each of the five exception modes has its own saved status word, which is reached with `psr_rd_sel`/`psr_wr_sel` = 1 and byte masks as in R7. In user, system or unlisted modes, saved-status reads return 0 and saved-status writes are ignored.
- R10: When `exc_en` is high, the next state holds the following. The target mode's saved status word equals the old status word, and its register 14 equals `exc_lr`. The status mode field equals `exc_mode`. Bit 7 is set, and bits 5 and 24 are cleared. Bit 6 is set when the target is fast-interrupt mode. General and status writes in that cycle are dropped.
- R11: Reads are combinational from stored state. A write becomes visible on the read ports in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Program counter from fetch, returned for register 15 |
| br_valid | output | 1 | Register 15 was written this cycle |
| br_target | output | 32 | Branch target from a register 15 write |
| psr_rd_sel | input | 1 | Status read select: 0 current, 1 saved |
| psr_rd_data | output | 32 | Status read data |
| psr_wr_en | input | 1 | Status write enable |
| psr_wr_sel | input | 1 | Status write select: 0 current, 1 saved |
| psr_wr_mask | input | 4 | Byte mask for status writes |
| psr_wr_data | input | 32 | Status write data |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode entered on exception |
| exc_lr | input | 32 | Return address loaded into the target mode's register 14 |
| cpsr_out | output | 32 | Current status word |

## Verification
The assertions check the following on every cycle: the register 15 read path and branch forwarding, the rule that unmasked status bytes and the whole lower three bytes in user mode stay untouched, the empty saved-status view in user and system modes, and the mode and mask-bit values after exception entry. The banking itself can only be shown by the bench's scenarios. These write distinct values in one mode and read them from every other mode. The same holds for the distinct saved status word per mode and for the dropping of writes that collide with exception entry. A behavioural reference model of the per-mode register views is compared against all outputs on every clock.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam int N_SHARED   = 15;
  localparam int N_FIQ_PRIV = 7;
  localparam int N_SAVED    = 5;
  localparam int FIQ_BASE   = N_SHARED;
  localparam int PRIV_BASE  = FIQ_BASE + N_FIQ_PRIV;
  localparam int N_PHYS     = PRIV_BASE + 2 * (N_SAVED - 1);

  localparam int BIT_J = 24;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  function automatic bank_e mode_bank(input logic [4:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic mode_priv(input logic [4:0] m);
    return (m == MD_SYS) || (mode_bank(m) != BK_USR);
  endfunction

endpackage

// File: rtl/breg_rst_sync.sv
module breg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/breg_bank_map.sv
module breg_bank_map
  import bregs_pkg::*;
#(
  parameter int PIDX_W = 5
) (
  input  bank_e             bank,
  input  logic [3:0]        idx,
  output logic [PIDX_W-1:0] phys,
  output logic              is_pc
);
  int pos;

  always_comb begin
    pos = int'(idx);
    if (idx >= 4'd8 && idx <= 4'd12) begin
      if (bank == BK_FIQ) pos = FIQ_BASE + int'(idx) - 8;
    end else if (idx == 4'd13 || idx == 4'd14) begin
      case (bank)
        BK_USR:  pos = int'(idx);
        BK_FIQ:  pos = FIQ_BASE + int'(idx) - 8;
        default: pos = PRIV_BASE + 2 * (int'(bank) - 2) + int'(idx) - 13;
      endcase
    end
    phys = PIDX_W'(pos);
  end

  assign is_pc = (idx == 4'd15);
endmodule

// File: rtl/breg_psr_unit.sv
module breg_psr_unit
  import bregs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW/8-1:0] wr_mask,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  output logic [DW-1:0] cpsr,
  output bank_e         cur_bank
);
  localparam int NB = DW / 8;
  localparam logic [DW-1:0] CPSR_RST =
    DW'({1'b1, 1'b1, 1'b0, MD_SVC});

  logic [DW-1:0] cpsr_q, cpsr_d;
  logic [DW-1:0] spsr_q [N_SAVED];
  logic [DW-1:0] spsr_d;
  logic [DW-1:0] cpsr_merge, spsr_merge, spsr_cur;
  logic [NB-1:0] cpsr_lane_we, spsr_lane_we;
  logic          priv, has_spsr, cpsr_en;
  logic [N_SAVED-1:0] spsr_en;
  bank_e         exc_bank;

  assign cur_bank = mode_bank(cpsr_q[4:0]);
  assign priv     = mode_priv(cpsr_q[4:0]);
  assign has_spsr = (cur_bank != BK_USR);
  assign exc_bank = mode_bank(exc_mode);

  always_comb begin
    spsr_cur = '0;
    for (int k = 0; k < N_SAVED; k++)
      if (int'(cur_bank) == k + 1) spsr_cur = spsr_q[k];
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cpsr_lane_we[b] = wr_en && !wr_sel && wr_mask[b] && (priv || b == NB - 1);
    assign spsr_lane_we[b] = wr_en && wr_sel && wr_mask[b] && has_spsr;
    assign cpsr_merge[8*b +: 8] = cpsr_lane_we[b] ? wr_data[8*b +: 8] : cpsr_q[8*b +: 8];
    assign spsr_merge[8*b +: 8] = spsr_lane_we[b] ? wr_data[8*b +: 8] : spsr_cur[8*b +: 8];
  end

  always_comb begin
    cpsr_d  = cpsr_merge;
    spsr_d  = spsr_merge;
    cpsr_en = |cpsr_lane_we;
    for (int k = 0; k < N_SAVED; k++)
      spsr_en[k] = (|spsr_lane_we) && (int'(cur_bank) == k + 1);
    if (exc_en) begin
      cpsr_d        = cpsr_q;
      cpsr_d[4:0]   = exc_mode;
      cpsr_d[BIT_I] = 1'b1;
      cpsr_d[BIT_T] = 1'b0;
      cpsr_d[BIT_J] = 1'b0;
      if (exc_bank == BK_FIQ) cpsr_d[BIT_F] = 1'b1;
      cpsr_en = 1'b1;
      spsr_d  = cpsr_q;
      for (int k = 0; k < N_SAVED; k++)
        spsr_en[k] = (int'(exc_bank) == k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpsr_q <= CPSR_RST;
    else if (cpsr_en) cpsr_q <= cpsr_d;
  end

  for (genvar k = 0; k < N_SAVED; k++) begin : g_spsr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          spsr_q[k] <= '0;
      else if (spsr_en[k]) spsr_q[k] <= spsr_d;
    end
  end

  assign cpsr    = cpsr_q;
  assign rd_data = rd_sel ? spsr_cur : cpsr_q;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] pc_in,
  output logic              br_valid,
  output logic [DATA_W-1:0] br_target,
  input  logic              psr_rd_sel,
  output logic [DATA_W-1:0] psr_rd_data,
  input  logic              psr_wr_en,
  input  logic              psr_wr_sel,
  input  logic [3:0]        psr_wr_mask,
  input  logic [DATA_W-1:0] psr_wr_data,
  input  logic              exc_en,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_lr,
  output logic [DATA_W-1:0] cpsr_out
);
  localparam int PIDX_W = $clog2(N_PHYS);
  localparam int N_MAP  = 4;
  localparam int P_RDA  = 0;
  localparam int P_RDB  = 1;
  localparam int P_WR   = 2;
  localparam int P_EXC  = 3;

  logic              rst_n_i;
  bank_e             cur_bank;
  logic [DATA_W-1:0] gpr_q [N_PHYS];
  logic [DATA_W-1:0] gpr_d [N_PHYS];
  logic [N_PHYS-1:0] gpr_en;
  logic              wr_go;

  logic [3:0]        map_idx  [N_MAP];
  bank_e             map_bank [N_MAP];
  logic [PIDX_W-1:0] map_phys [N_MAP];
  logic              map_pc   [N_MAP];

  breg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  breg_psr_unit #(.DW(DATA_W)) u_psr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (psr_wr_en),
    .wr_sel   (psr_wr_sel),
    .wr_mask  (psr_wr_mask),
    .wr_data  (psr_wr_data),
    .rd_sel   (psr_rd_sel),
    .rd_data  (psr_rd_data),
    .exc_en   (exc_en),
    .exc_mode (exc_mode),
    .cpsr     (cpsr_out),
    .cur_bank (cur_bank)
  );

  assign map_idx[P_RDA]  = rd_a_idx;
  assign map_idx[P_RDB]  = rd_b_idx;
  assign map_idx[P_WR]   = wr_idx;
  assign map_idx[P_EXC]  = 4'd14;
  assign map_bank[P_RDA] = cur_bank;
  assign map_bank[P_RDB] = cur_bank;
  assign map_bank[P_WR]  = cur_bank;
  assign map_bank[P_EXC] = mode_bank(exc_mode);

  for (genvar p = 0; p < N_MAP; p++) begin : g_map
    breg_bank_map #(.PIDX_W(PIDX_W)) u_map (
      .bank  (map_bank[p]),
      .idx   (map_idx[p]),
      .phys  (map_phys[p]),
      .is_pc (map_pc[p])
    );
  end

  assign wr_go = wr_en && !exc_en && !map_pc[P_WR];

  for (genvar k = 0; k < N_PHYS; k++) begin : g_gpr
    logic hit_w, hit_x;
    assign hit_x    = exc_en && (map_phys[P_EXC] == PIDX_W'(k));
    assign hit_w    = wr_go && (map_phys[P_WR] == PIDX_W'(k));
    assign gpr_en[k] = hit_w || hit_x;
    assign gpr_d[k]  = hit_x ? exc_lr : wr_data;

    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i)       gpr_q[k] <= '0;
      else if (gpr_en[k]) gpr_q[k] <= gpr_d[k];
    end
  end

  assign rd_a_data = map_pc[P_RDA] ? pc_in : gpr_q[map_phys[P_RDA]];
  assign rd_b_data = map_pc[P_RDB] ? pc_in : gpr_q[map_phys[P_RDB]];
  assign br_valid  = wr_en && !exc_en && map_pc[P_WR];
  assign br_target = wr_data;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [31:0] pc_in,
  input logic        br_valid,
  input logic [31:0] br_target,
  input logic        psr_rd_sel,
  input logic [31:0] psr_rd_data,
  input logic        psr_wr_en,
  input logic        psr_wr_sel,
  input logic [3:0]  psr_wr_mask,
  input logic        exc_en,
  input logic [4:0]  exc_mode,
  input logic [31:0] cpsr_out
);
  p_pc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'hF) |-> (rd_a_data == pc_in));

  p_pc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'hF && !exc_en) |-> (br_valid && br_target == wr_data));

  p_exc_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |=> (cpsr_out[4:0] == $past(exc_mode) && cpsr_out[7] && !cpsr_out[5]));

  p_user_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_out[4:0] == 5'b10000 && !exc_en) |=> (cpsr_out[23:0] == $past(cpsr_out[23:0])));

  p_spsr_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_rd_sel && (cpsr_out[4:0] == 5'b10000 || cpsr_out[4:0] == 5'b11111))
      |-> (psr_rd_data == 32'h0));

  p_flag_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !psr_wr_sel && !psr_wr_mask[3] && !exc_en)
      |=> (cpsr_out[31:24] == $past(cpsr_out[31:24])));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .pc_in       (pc_in),
  .br_valid    (br_valid),
  .br_target   (br_target),
  .psr_rd_sel  (psr_rd_sel),
  .psr_rd_data (psr_rd_data),
  .psr_wr_en   (psr_wr_en),
  .psr_wr_sel  (psr_wr_sel),
  .psr_wr_mask (psr_wr_mask),
  .exc_en      (exc_en),
  .exc_mode    (exc_mode),
  .cpsr_out    (cpsr_out)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_in, br_target;
  logic        wr_en, br_valid, psr_rd_sel, psr_wr_en, psr_wr_sel, exc_en;
  logic [31:0] psr_rd_data, psr_wr_data, exc_lr, cpsr_out;
  logic [3:0]  psr_wr_mask;
  logic [4:0]  exc_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: one full register view per mode group
  logic [31:0] mv [6][15];
  logic [31:0] m_spsr [6];
  logic [31:0] m_cpsr;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_in(pc_in), .br_valid(br_valid), .br_target(br_target),
    .psr_rd_sel(psr_rd_sel), .psr_rd_data(psr_rd_data),
    .psr_wr_en(psr_wr_en), .psr_wr_sel(psr_wr_sel),
    .psr_wr_mask(psr_wr_mask), .psr_wr_data(psr_wr_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_lr(exc_lr),
    .cpsr_out(cpsr_out)
  );

  function automatic int vw(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit is_priv(input logic [4:0] m);
    return (m == 5'b11111) || (vw(m) != 0);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] i);
    if (i == 4'd15) return pc_in;
    return mv[vw(m_cpsr[4:0])][i];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < 6; v++) begin
      m_spsr[v] = '0;
      for (int r = 0; r < 15; r++) mv[v][r] = '0;
    end
    m_cpsr = 32'h0000_00D3;
  endtask

  task automatic model_update();
    int cm, t;
    cm = vw(m_cpsr[4:0]);
    if (exc_en) begin
      t = vw(exc_mode);
      if (t != 0) m_spsr[t] = m_cpsr;
      mv[t][14] = exc_lr;
      m_cpsr[4:0] = exc_mode;
      m_cpsr[7] = 1'b1;
      m_cpsr[5] = 1'b0;
      m_cpsr[24] = 1'b0;
      if (t == 1) m_cpsr[6] = 1'b1;
      return;
    end
    if (wr_en && wr_idx != 4'd15)
      for (int v = 0; v < 6; v++)
        if (wr_idx < 8 || (wr_idx < 13 && ((v == 1) == (cm == 1))) || v == cm)
          mv[v][wr_idx] = wr_data;
    if (psr_wr_en)
      for (int b = 0; b < 4; b++)
        if (psr_wr_mask[b]) begin
          if (!psr_wr_sel && (is_priv(m_cpsr[4:0]) || b == 3))
            m_cpsr[8*b +: 8] = psr_wr_data[8*b +: 8];
          else if (psr_wr_sel && cm != 0)
            m_spsr[cm][8*b +: 8] = psr_wr_data[8*b +: 8];
        end
  endtask

  // compare every output, then let one clock edge pass (R11: reads reflect state before the edge)
  task automatic step(input string tag);
    #2;
    check(tag, "rd_a", rd_a_data, exp_rd(rd_a_idx));
    check(tag, "rd_b", rd_b_data, exp_rd(rd_b_idx));
    check(tag, "cpsr", cpsr_out, m_cpsr);
    check(tag, "psr_rd", psr_rd_data,
          psr_rd_sel ? (vw(m_cpsr[4:0]) != 0 ? m_spsr[vw(m_cpsr[4:0])] : 32'h0) : m_cpsr);
    check(tag, "br_valid", {31'h0, br_valid}, {31'h0, wr_en && !exc_en && wr_idx == 4'd15});
    if (br_valid) check(tag, "br_target", br_target, wr_data);
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
    wr_en = 0; psr_wr_en = 0; exc_en = 0;
  endtask

  task automatic do_wr(input logic [3:0] i, input logic [31:0] d, input string tag);
    wr_en = 1; wr_idx = i; wr_data = d; step(tag);
  endtask

  task automatic do_psr(input logic sel, input logic [3:0] m, input logic [31:0] d,
                        input string tag);
    psr_wr_en = 1; psr_wr_sel = sel; psr_wr_mask = m; psr_wr_data = d; step(tag);
  endtask

  task automatic do_exc(input logic [4:0] m, input logic [31:0] lr, input string tag);
    exc_en = 1; exc_mode = m; exc_lr = lr; step(tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 15; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(14 - i); step(tag);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; psr_wr_en = 0; exc_en = 0;
    rd_a_idx = 0; rd_b_idx = 1; wr_idx = 0; wr_data = 0; pc_in = 32'h0000_8000;
    psr_rd_sel = 0; psr_wr_sel = 0; psr_wr_mask = 0; psr_wr_data = 0;
    exc_mode = 5'b10011; exc_lr = 0;
    model_reset();
    @(negedge clk);
    repeat (3) step("R1");
    rst_n = 1;
    repeat (3) step("R1");
    sweep("R1");

    // supervisor: fill r0..r14
    for (int i = 0; i < 15; i++) begin
      rd_a_idx = 4'(i); do_wr(4'(i), 32'h1000_0000 + 32'(i * 17), "R2");
    end
    rd_a_idx = 4'd14; step("R11");
    sweep("R2");

    // fast-interrupt: private r8..r14
    do_psr(0, 4'b0001, 32'h0000_00D1, "R7");
    sweep("R3");
    for (int i = 8; i < 15; i++) do_wr(4'(i), 32'h2000_0000 + 32'(i), "R3");
    do_wr(4'd2, 32'h2222_0002, "R2");
    sweep("R3");

    // IRQ: shared r8..r12, private r13/r14
    do_psr(0, 4'b0001, 32'h0000_00D2, "R7");
    sweep("R4");
    do_wr(4'd13, 32'h3000_000D, "R4");
    do_wr(4'd14, 32'h3000_000E, "R4");
    do_wr(4'd10, 32'h3000_000A, "R4");
    sweep("R4");
    do_psr(0, 4'b0001, 32'h0000_00D3, "R7");
    sweep("R4");
    do_psr(0, 4'b0001, 32'h0000_00D7, "R7");
    sweep("R4");
    do_psr(0, 4'b0001, 32'h0000_00DB, "R7");
    do_wr(4'd13, 32'h5000_000D, "R4");
    sweep("R4");

    // system mode and an unlisted encoding share the user view
    do_psr(0, 4'b0001, 32'h0000_00DF, "R5");
    sweep("R5");
    do_wr(4'd13, 32'h6000_000D, "R5");
    psr_rd_sel = 1;
    do_psr(1, 4'b1111, 32'hDEAD_BEEF, "R9");
    step("R9");
    psr_rd_sel = 0;
    do_psr(0, 4'b0001, 32'h0000_00D5, "R5");
    sweep("R5");
    do_psr(0, 4'b1111, 32'hFFFF_FFFF, "R8");
    step("R8");
    do_exc(5'b10011, 32'h7000_0004, "R10");
    sweep("R10");

    // register 15 forwarding
    pc_in = 32'h0001_2344; rd_a_idx = 4'd15; rd_b_idx = 4'd15;
    do_wr(4'd15, 32'hCAFE_0000, "R6");
    pc_in = 32'hFFFF_FFFC; step("R6");
    sweep("R6");

    // privileged status byte masks
    do_psr(0, 4'b1000, 32'hF000_0000, "R7");
    do_psr(0, 4'b0100, 32'h00AB_0000, "R7");
    do_psr(0, 4'b0010, 32'h0000_CD00, "R7");
    do_psr(0, 4'b0101, 32'h0012_0093, "R7");
    do_psr(0, 4'b1010, 32'h5555_1255, "R7");

    // saved status per mode
    psr_rd_sel = 1;
    do_psr(1, 4'b1111, 32'hA5A5_0013, "R9");
    do_psr(0, 4'b0001, 32'h0000_00D7, "R9");
    step("R9");
    do_psr(1, 4'b1001, 32'h5A00_0017, "R9");
    do_psr(0, 4'b0001, 32'h0000_00D2, "R9");
    do_psr(1, 4'b0110, 32'h0033_4400, "R9");
    do_psr(0, 4'b0001, 32'h0000_00D3, "R9");
    step("R9");
    do_psr(0, 4'b0001, 32'h0000_00D7, "R9");
    step("R9");

    // exception entry with colliding writes dropped
    wr_en = 1; wr_idx = 4'd3; wr_data = 32'hBAD0_0003;
    psr_wr_en = 1; psr_wr_sel = 0; psr_wr_mask = 4'b1111; psr_wr_data = 32'h0000_0010;
    do_exc(5'b10001, 32'h8000_0010, "R10");
    step("R10");
    sweep("R10");

    // user mode: only flag byte writable, no saved status
    do_psr(0, 4'b0001, 32'h0000_0010, "R8");
    do_psr(0, 4'b1111, 32'h0F0F_FFFF, "R8");
    do_psr(0, 4'b0111, 32'h00FF_FF1F, "R8");
    do_psr(1, 4'b1111, 32'h1234_5678, "R9");
    step("R9");
    do_wr(4'd13, 32'h9000_000D, "R5");
    sweep("R5");
    do_exc(5'b11011, 32'h9000_0020, "R10");
    sweep("R10");
    psr_rd_sel = 0;
    step("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule